// File: doc/BRIEF.md
# Multi-Mode Protected Register File

This block is a 32-entry, 32-bit register file built from flip-flops. Each entry stores a 32-bit data field and a 7-bit check field. Every access carries a 3-bit mode code, and that code picks one of five protection schemes:

- a single-error-correct, double-error-detect code;
- triple redundancy with a majority vote;
- a plain shadow copy;
- a code-protected shadow copy;
- no protection.

All five schemes share the same 32 physical entries. The redundant copies and the stored check bits sit at fixed index remappings inside that array. Software must use the indices that suit the chosen scheme.

A read is registered: the data and a 2-bit status appear after the clock edge that samples the read strobe. The outputs then hold until the next read. A fault-injection port XORs a raw 39-bit mask into one entry. This lets a test flip any data or check bit and then observe how each scheme reports the damage.

Top module: `prf_top`

## Requirements
- R1: An active-low reset clears every entry and both read outputs to zero. `ready` is 0 while reset is asserted and becomes 1 after the first clock edge following release.
- R2: A read presents `rdData`/`status` after the edge that samples `rdEn`. With `rdEn` low, both outputs hold their values. A read and a write in the same cycle return the contents from before the write.
- R3: Mode 000 stores the data in entry bits [31:0] and the check bits in [38:32]. A read reports 00 when the entry is clean. A single flipped bit anywhere in the 39 bits returns the corrected data with status 01. Two flipped bits give status 10.
- R4: Status codes are 00 for clean data, 01 for corrected data and 10 for uncorrectable data. Status 11 never appears.
- R5: Mode 001 clears the two low index bits to form a base. It writes the word to base, base+1 and base+2, and the word's check bits to bits [6:0] of base+3. A read reports 00 when all three copies agree. When exactly two copies agree, it returns the bitwise majority with status 01.
- R6: In mode 001, when no two copies agree, the voted word is checked against the check bits in base+3. A clean or single-error result returns the corrected word with status 01. A double error gives status 10.
- R7: Mode 011 uses index bits [3:0] only. It writes the raw word to that entry and to entry+16. A read returns the primary data, with status 10 on any mismatch between the two copies and 00 otherwise. It never reports 01.
- R8: Mode 010 writes the coded word to index[3:0] and to index[3:0]+16. A read decodes the primary entry. The status is 10 when the decode is uncorrectable or when the decoded data differs from the shadow data. Otherwise it is the decode status.
- R9: Mode 100 stores the raw data with a zero check field. A read returns the stored data unchanged, with status 00.
- R10: Mode codes 101, 110 and 111 write nothing. A read with one of these codes returns zero data with status 00.
- R11: With `injEn` high, entry `injIdx` becomes its old value XOR `injMask`. A normal write to that entry in the same cycle is dropped. The other entries targeted by that write are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 32 | Word to store |
| regIdx | input | 5 | Register index |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| mode | input | 3 | Protection mode code |
| injEn | input | 1 | Fault-injection strobe |
| injIdx | input | 5 | Entry to modify |
| injMask | input | 39 | Bits to flip in that entry |
| rdData | output | 32 | Read data |
| status | output | 2 | Read result status |
| ready | output | 1 | Accepting accesses |

## Verification
A wrong remapping or a bad encoder never shows up when an access simply writes and then reads back the same word. It only surfaces on the first read that follows an injected flip, which is one cycle after the read strobe. The result is a wrong status code, or a corrected word that is off by one bit. The bench therefore sweeps a single flip and a double flip across all 39 bit positions of one entry. It also damages every replica location for each redundant scheme. Within each mode, it then compares the status and data from that one-cycle-late read against arithmetic expectations.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 5;
  localparam int NUM_ENT  = 1 << IDX_W;
  localparam int HAM_W    = 6;
  localparam int CHK_W    = HAM_W + 1;
  localparam int ENT_W    = DATA_W + CHK_W;
  localparam int CODE_LEN = DATA_W + HAM_W;

  typedef enum logic [2:0] {
    MODE_SECDED = 3'b000,
    MODE_TRIPLE = 3'b001,
    MODE_SHCODE = 3'b010,
    MODE_SHRAW  = 3'b011,
    MODE_BARE   = 3'b100
  } modeE;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_BAD   = 2'b10
  } statE;

  typedef struct packed {
    logic [NUM_ENT-1:0] wrWord;
    logic [NUM_ENT-1:0] wrChk;
    logic               wrRaw;
    logic               rdGo;
    modeE               rdMode;
    logic [IDX_W-1:0]   idxA;
    logic [IDX_W-1:0]   idxB;
    logic [IDX_W-1:0]   idxC;
    logic [IDX_W-1:0]   idxD;
  } strobeT;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    statE              st;
  } decT;

  // Hamming parity = XOR of the code positions of all set data bits
  function automatic logic [HAM_W-1:0] hamParity(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0]  acc;
    logic [HAM_W-1:0]  pv;
    logic [DATA_W-1:0] sh;
    acc = '0;
    sh  = d;
    for (int pos = 3; pos <= CODE_LEN; pos++) begin
      pv = HAM_W'(pos);
      if ((pv & (pv - 1'b1)) != '0) begin
        if (sh[0]) acc = acc ^ pv;
        sh = sh >> 1;
      end
    end
    return acc;
  endfunction

  function automatic logic [CHK_W-1:0] secdedEnc(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] p;
    p = hamParity(d);
    return {(^d) ^ (^p), p};
  endfunction

  function automatic decT secdedDec(input logic [DATA_W-1:0] d,
                                    input logic [CHK_W-1:0]  c);
    logic [HAM_W-1:0]  syn;
    logic              odd;
    logic [DATA_W-1:0] fix;
    logic [DATA_W-1:0] bitSel;
    logic [HAM_W-1:0]  pv;
    decT               r;
    syn    = hamParity(d) ^ c[HAM_W-1:0];
    odd    = ^{d, c};
    fix    = '0;
    bitSel = DATA_W'(1);
    for (int pos = 3; pos <= CODE_LEN; pos++) begin
      pv = HAM_W'(pos);
      if ((pv & (pv - 1'b1)) != '0) begin
        if (pv == syn) fix = fix | bitSel;
        bitSel = bitSel << 1;
      end
    end
    r.data = d;
    r.st   = ST_CLEAN;
    if (odd) begin
      if (syn <= HAM_W'(CODE_LEN)) begin
        r.data = d ^ fix;
        r.st   = ST_FIXED;
      end else begin
        r.st = ST_BAD;
      end
    end else if (syn != '0) begin
      r.st = ST_BAD;
    end
    return r;
  endfunction
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       mode,
  input  logic [IDX_W-1:0] regIdx,
  output strobeT           strobe,
  output logic             ready
);
  localparam int GRP_LO = 2;

  logic [IDX_W-1:0] baseIdx;
  logic [IDX_W-1:0] primIdx;
  logic [IDX_W-1:0] shadIdx;
  logic             readyQ;

  assign baseIdx = {regIdx[IDX_W-1:GRP_LO], GRP_LO'(0)};
  assign primIdx = {1'b0, regIdx[IDX_W-2:0]};
  assign shadIdx = {1'b1, regIdx[IDX_W-2:0]};

  always_comb begin
    strobe        = '0;
    strobe.rdGo   = rdEn;
    strobe.rdMode = modeE'(mode);
    case (modeE'(mode))
      MODE_SECDED: begin
        strobe.idxA = regIdx;
        if (wrEn) strobe.wrWord[regIdx] = 1'b1;
      end
      MODE_TRIPLE: begin
        strobe.idxA = baseIdx;
        strobe.idxB = baseIdx | IDX_W'(1);
        strobe.idxC = baseIdx | IDX_W'(2);
        strobe.idxD = baseIdx | IDX_W'(3);
        if (wrEn) begin
          strobe.wrWord[baseIdx | IDX_W'(0)] = 1'b1;
          strobe.wrWord[baseIdx | IDX_W'(1)] = 1'b1;
          strobe.wrWord[baseIdx | IDX_W'(2)] = 1'b1;
          strobe.wrChk[baseIdx | IDX_W'(3)]  = 1'b1;
        end
      end
      MODE_SHCODE, MODE_SHRAW: begin
        strobe.idxA  = primIdx;
        strobe.idxB  = shadIdx;
        strobe.wrRaw = (modeE'(mode) == MODE_SHRAW);
        if (wrEn) begin
          strobe.wrWord[primIdx] = 1'b1;
          strobe.wrWord[shadIdx] = 1'b1;
        end
      end
      MODE_BARE: begin
        strobe.idxA  = regIdx;
        strobe.wrRaw = 1'b1;
        if (wrEn) strobe.wrWord[regIdx] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign ready = readyQ;
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injEn,
  input  logic [IDX_W-1:0]  injIdx,
  input  logic [ENT_W-1:0]  injMask,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        status
);
  logic [ENT_W-1:0]  memArr [NUM_ENT];
  logic [CHK_W-1:0]  encWr;
  logic [ENT_W-1:0]  wordVal;
  logic [ENT_W-1:0]  chkVal;

  assign encWr   = secdedEnc(wrData);
  assign wordVal = strobe.wrRaw ? {CHK_W'(0), wrData} : {encWr, wrData};
  assign chkVal  = ENT_W'(encWr);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                q <= '0;
      else if (injEn && injIdx == IDX_W'(e))    q <= q ^ injMask;
      else if (strobe.wrWord[e])                q <= wordVal;
      else if (strobe.wrChk[e])                 q <= chkVal;
    end
    assign memArr[e] = q;
  end

  logic [DATA_W-1:0] cpA, cpB, cpC, vote;
  logic [CHK_W-1:0]  chkA, chkD;
  decT               decA, decV;
  logic [DATA_W-1:0] nxtData;
  statE              nxtSt;
  logic [DATA_W-1:0] rdDataQ;
  statE              statusQ;

  assign cpA  = memArr[strobe.idxA][DATA_W-1:0];
  assign chkA = memArr[strobe.idxA][ENT_W-1:DATA_W];
  assign cpB  = memArr[strobe.idxB][DATA_W-1:0];
  assign cpC  = memArr[strobe.idxC][DATA_W-1:0];
  assign chkD = memArr[strobe.idxD][CHK_W-1:0];
  assign vote = (cpA & cpB) | (cpA & cpC) | (cpB & cpC);
  assign decA = secdedDec(cpA, chkA);
  assign decV = secdedDec(vote, chkD);

  always_comb begin
    nxtData = '0;
    nxtSt   = ST_CLEAN;
    case (strobe.rdMode)
      MODE_SECDED: begin
        nxtData = decA.data;
        nxtSt   = decA.st;
      end
      MODE_TRIPLE: begin
        if (cpA == cpB && cpB == cpC) begin
          nxtData = cpA;
        end else if (cpA == cpB || cpA == cpC || cpB == cpC) begin
          nxtData = vote;
          nxtSt   = ST_FIXED;
        end else begin
          nxtData = decV.data;
          nxtSt   = (decV.st == ST_BAD) ? ST_BAD : ST_FIXED;
        end
      end
      MODE_SHCODE: begin
        nxtData = decA.data;
        if (decA.st == ST_BAD || decA.data != cpB) nxtSt = ST_BAD;
        else                                       nxtSt = decA.st;
      end
      MODE_SHRAW: begin
        nxtData = cpA;
        nxtSt   = (cpA != cpB) ? ST_BAD : ST_CLEAN;
      end
      MODE_BARE: nxtData = cpA;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      statusQ <= ST_CLEAN;
    end else if (strobe.rdGo) begin
      rdDataQ <= nxtData;
      statusQ <= nxtSt;
    end
  end

  assign rdData = rdDataQ;
  assign status = statusQ;
endmodule

// File: rtl/prf_top.sv
module prf_top
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        mode,
  input  logic              injEn,
  input  logic [IDX_W-1:0]  injIdx,
  input  logic [ENT_W-1:0]  injMask,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        status,
  output logic              ready
);
  strobeT strobe;

  prf_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .mode   (mode),
    .regIdx (regIdx),
    .strobe (strobe),
    .ready  (ready)
  );

  prf_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .injEn   (injEn),
    .injIdx  (injIdx),
    .injMask (injMask),
    .rdData  (rdData),
    .status  (status)
  );
endmodule

// File: rtl/prf_chk.sv
module prf_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [2:0]  mode,
  input logic [31:0] rdData,
  input logic [1:0]  status,
  input logic        ready
);
  // R4
  status_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b11);

  // R1
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> ($stable(rdData) && $stable(status)));

  // R9
  bare_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode == 3'b100) |=> status == 2'b00);

  // R7
  shadow_no_fix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode == 3'b011) |=> status != 2'b01);

  // R10
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode >= 3'b101) |=> (rdData == 32'd0 && status == 2'b00));
endmodule

bind prf_top prf_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .rdEn   (rdEn),
  .mode   (mode),
  .rdData (rdData),
  .status (status),
  .ready  (ready)
);

// File: tb/prf_top_tb_top.sv
`timescale 1ns/1ps
module prf_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic [4:0]  regIdx = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  mode = '0;
  logic        injEn = 1'b0;
  logic [4:0]  injIdx = '0;
  logic [38:0] injMask = '0;
  logic [31:0] rdData;
  logic [1:0]  status;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prf_top dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .regIdx(regIdx), .wrEn(wrEn),
    .rdEn(rdEn), .mode(mode), .injEn(injEn), .injIdx(injIdx), .injMask(injMask),
    .rdData(rdData), .status(status), .ready(ready)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0F1E ^ (32'(i) * 32'h0101_0111) ^ (32'(i) << 27);
  endfunction

  task automatic check(input string tag, input logic [31:0] gotD, input logic [31:0] expD,
                       input bit useD, input logic [1:0] gotS, input logic [1:0] expS);
    checks++;
    if ((useD && gotD !== expD) || gotS !== expS) begin
      errors++;
      $display("FAIL %s data %h exp %h status %b exp %b", tag, gotD, expD, gotS, expS);
    end
  endtask

  task automatic doWrite(input logic [2:0] m, input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    mode = m; regIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic inject(input logic [4:0] e, input logic [38:0] msk);
    @(negedge clk);
    injIdx = e; injMask = msk; injEn = 1'b1;
    @(negedge clk);
    injEn = 1'b0;
  endtask

  task automatic readChk(input string tag, input logic [2:0] m, input logic [4:0] idx,
                         input logic [31:0] expD, input bit useD, input logic [1:0] expS);
    @(negedge clk);
    mode = m; regIdx = idx; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, expD, useD, status, expS);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", rdData, 32'd0, 1'b1, status, 2'b00);
    check("R1 ready low", {31'd0, ready}, 32'd0, 1'b1, 2'b00, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready high", {31'd0, ready}, 32'd1, 1'b1, 2'b00, 2'b00);

    // R3 code mode sweep over all entries
    for (int i = 0; i < 32; i++) doWrite(3'b000, 5'(i), pat(i));
    for (int i = 0; i < 32; i++) readChk("R3 clean", 3'b000, 5'(i), pat(i), 1'b1, 2'b00);

    // R2 hold with no read
    repeat (3) @(negedge clk);
    check("R2 hold", rdData, pat(31), 1'b1, status, 2'b00);

    // R2 read and write in the same cycle
    @(negedge clk);
    mode = 3'b000; regIdx = 5'd2; wrData = 32'h1234_5678; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R2 read-before-write", rdData, pat(2), 1'b1, status, 2'b00);
    readChk("R2 new value", 3'b000, 5'd2, 32'h1234_5678, 1'b1, 2'b00);

    // R3 single and double flips over all 39 bit positions
    for (int b = 0; b < 39; b++) begin
      v = pat(b + 40);
      doWrite(3'b000, 5'd5, v);
      inject(5'd5, 39'd1 << b);
      readChk("R3 single flip", 3'b000, 5'd5, v, 1'b1, 2'b01);
    end
    for (int b = 0; b < 39; b++) begin
      v = pat(b + 90);
      doWrite(3'b000, 5'd5, v);
      inject(5'd5, (39'd1 << b) | (39'd1 << ((b + 7) % 39)));
      readChk("R4 R3 double flip", 3'b000, 5'd5, v, 1'b0, 2'b10);
    end

    // R1 reset clears every entry
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 ready low again", {31'd0, ready}, 32'd0, 1'b1, status, 2'b00);
    rstN = 1'b1;
    for (int i = 0; i < 32; i++) readChk("R1 cleared", 3'b100, 5'(i), 32'd0, 1'b1, 2'b00);

    // R5 triple redundancy: write, copies, single-copy damage
    for (int k = 0; k < 8; k++) begin
      v = pat(k + 200);
      doWrite(3'b001, 5'(4 * k + (k % 4)), v);
      readChk("R5 clean", 3'b001, 5'(4 * k), v, 1'b1, 2'b00);
      readChk("R5 copy1", 3'b100, 5'(4 * k + 1), v, 1'b1, 2'b00);
      readChk("R5 copy2", 3'b100, 5'(4 * k + 2), v, 1'b1, 2'b00);
      inject(5'(4 * k + (k % 3)), 39'd1 << k);
      readChk("R5 one copy bad", 3'b001, 5'(4 * k + 3), v, 1'b1, 2'b01);
    end
    // R6 no two copies agree
    for (int k = 0; k < 8; k++) begin
      v = pat(k + 300);
      doWrite(3'b001, 5'(4 * k), v);
      inject(5'(4 * k), 39'h1);
      inject(5'(4 * k + 1), 39'h3);
      readChk("R6 vote then code fix", 3'b001, 5'(4 * k), v, 1'b1, 2'b01);
      doWrite(3'b001, 5'(4 * k), v);
      inject(5'(4 * k), 39'h3);
      inject(5'(4 * k + 1), 39'h23);
      readChk("R6 vote then double", 3'b001, 5'(4 * k), v, 1'b0, 2'b10);
    end

    // R7 plain shadow
    for (int i = 0; i < 16; i++) begin
      v = pat(i + 400);
      doWrite(3'b011, {1'(i & 1), 4'(i)}, v);
      readChk("R7 clean", 3'b011, 5'(i), v, 1'b1, 2'b00);
      readChk("R7 copy", 3'b100, 5'(i + 16), v, 1'b1, 2'b00);
      inject(5'(i + 16), 39'd1 << i);
      readChk("R7 shadow bad", 3'b011, 5'(i), v, 1'b1, 2'b10);
      inject(5'(i), 39'd1 << (i + 3));
      readChk("R7 both bad", 3'b011, 5'(i), v ^ (32'd1 << (i + 3)), 1'b1, 2'b10);
    end

    // R8 code-protected shadow
    for (int i = 0; i < 16; i++) begin
      v = pat(i + 500);
      doWrite(3'b010, 5'(i), v);
      readChk("R8 clean", 3'b010, 5'(i), v, 1'b1, 2'b00);
      inject(5'(i), 39'd1 << (i + 2));
      readChk("R8 primary fixed", 3'b010, 5'(i), v, 1'b1, 2'b01);
      doWrite(3'b010, 5'(i), v);
      inject(5'(i + 16), 39'd1 << i);
      readChk("R8 shadow differs", 3'b010, 5'(i), v, 1'b1, 2'b10);
      doWrite(3'b010, 5'(i), v);
      inject(5'(i), 39'h5 << i);
      readChk("R8 primary double", 3'b010, 5'(i), v, 1'b0, 2'b10);
    end

    // R9 no protection
    v = 32'hDEAD_BEEF;
    doWrite(3'b100, 5'd20, v);
    readChk("R9 clean", 3'b100, 5'd20, v, 1'b1, 2'b00);
    inject(5'd20, 39'h80);
    readChk("R9 flipped raw", 3'b100, 5'd20, v ^ 32'h80, 1'b1, 2'b00);

    // R10 reserved codes
    doWrite(3'b000, 5'd3, 32'h0BAD_F00D);
    doWrite(3'b101, 5'd3, 32'h1111_1111);
    doWrite(3'b110, 5'd3, 32'h2222_2222);
    doWrite(3'b111, 5'd3, 32'h3333_3333);
    readChk("R10 write ignored", 3'b000, 5'd3, 32'h0BAD_F00D, 1'b1, 2'b00);
    readChk("R10 read zero", 3'b111, 5'd3, 32'd0, 1'b1, 2'b00);

    // R11 injection wins over a same-cycle write
    doWrite(3'b000, 5'd7, 32'h7777_0001);
    @(negedge clk);
    mode = 3'b000; regIdx = 5'd7; wrData = 32'h9999_9999; wrEn = 1'b1;
    injIdx = 5'd7; injMask = 39'h1; injEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; injEn = 1'b0;
    readChk("R11 write dropped", 3'b000, 5'd7, 32'h7777_0001, 1'b1, 2'b01);
    doWrite(3'b000, 5'd13, 32'h0000_0000);
    @(negedge clk);
    mode = 3'b001; regIdx = 5'd12; wrData = 32'hC0DE_CAFE; wrEn = 1'b1;
    injIdx = 5'd13; injMask = 39'h10; injEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; injEn = 1'b0;
    readChk("R11 other copies written", 3'b001, 5'd12, 32'hC0DE_CAFE, 1'b1, 2'b01);
    readChk("R11 injected entry", 3'b100, 5'd13, 32'h0000_0010, 1'b1, 2'b00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule